// File: doc/BRIEF.md
# Transmit Line-Fault Interval Counter

This block measures how long carrier stays present after a frame transmission starts. The interval is an aid to locating cable faults such as opens and shorts. A start-of-transmit strobe clears a 10-bit interval counter and arms it. While it is armed and carrier is present, the counter advances once for each cycle that an externally generated 10 MHz tick enable is high. When carrier drops, the measurement ends and the count holds its value until the next frame starts. The counter stops at its maximum value and does not wrap.

Host software reads the result through a small strobe-based register port. A read is answered only while the device is in stop mode. Outside stop mode a read produces no valid data. Write strobes are accepted on the port but have no effect on the count. A hard reset clears the count and disarms the counter; a soft reset does the same.

Top module: `tdr_interval_counter`

## Requirements
- R1: The read word carries the count in bits 9..0, and bits 15..10 always read as zero. While `rd_valid` is low, the whole read word is zero.
- R2: A `tx_start` pulse clears the count to 0 and arms the measurement at the following clock edge.
- R3: While the measurement is armed and `carrier` is high, the count rises by exactly one at each edge where `tick` is high. It does not change at edges where `tick` is low.
- R4: When `carrier` is low while the measurement is armed, the measurement ends. The count then stays frozen, whatever `tick` does, until the next `tx_start`.
- R5: The count saturates at 1023 and never wraps to 0.
- R6: An active-low asynchronous `hrst_n` clears the count to zero and disarms the measurement. So does a synchronous active-high `srst`. `srst` takes priority over a `tx_start` in the same cycle, and it also clears `rd_valid` and `rd_data`.
- R7: A read (`rd_en` high, `wr_en` low) while `stop_mode` is high raises `rd_valid` for one cycle after the edge. `rd_data` then holds the count as it stood before that edge, including when that edge also increments the count.
- R8: A read while `stop_mode` is low leaves `rd_valid` low and `rd_data` zero.
- R9: `wr_en` has no effect on the count. A cycle with both `rd_en` and `wr_en` high is treated as a write, and it returns no data.
- R10: When `tx_start` and `tick` are high in the same cycle of an armed measurement, the start wins and the count is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hrst_n | input | 1 | Hard reset, asynchronous, active low |
| srst | input | 1 | Soft reset, synchronous, active high |
| tx_start | input | 1 | One-cycle strobe at the start of a frame transmission |
| carrier | input | 1 | Carrier sense, high while carrier is present |
| tick | input | 1 | One-cycle 10 MHz count enable |
| stop_mode | input | 1 | High while the device is stopped; gates reads |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe (ignored by the count) |
| rd_data | output | 16 | Read word: zero-extended count |
| rd_valid | output | 1 | High for one cycle with valid read data |

## Verification
Two pairs of functions can meet in one cycle. The first is a transmit start and a count tick. The second is a register read and a count increment. The bench drives `tx_start` and `tick` high together during a running measurement, and it expects the count to read 0 afterwards. It also issues a read on the same edge as a tick, and it expects the pre-increment value, with the incremented value visible on a second read. A behavioural model in the bench tracks every edge and is compared on each clock, so any disagreement in these collision cycles shows up as soon as it happens.

// File: rtl/tdr_interval_counter.sv
module tdr_interval_counter #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              hrst_n,
  input  logic              srst,
  input  logic              tx_start,
  input  logic              carrier,
  input  logic              tick,
  input  logic              stop_mode,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int PAD_W = DATA_W - CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             armed;

  wire rd_take = rd_en & ~wr_en & stop_mode;
  wire at_max  = (cnt == CNT_MAX);
  wire bump    = armed & carrier & tick & ~at_max;

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (srst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (tx_start) begin
      cnt   <= '0;
      armed <= 1'b1;
    end else if (armed && !carrier) begin
      armed <= 1'b0;
    end else if (bump) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (srst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_take;
      rd_data  <= rd_take ? {{PAD_W{1'b0}}, cnt} : '0;
    end
  end

endmodule

// File: rtl/tdr_interval_counter_chk.sv
module tdr_interval_counter_chk #(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              hrst_n,
  input logic              srst,
  input logic              tx_start,
  input logic              carrier,
  input logic              tick,
  input logic              stop_mode,
  input logic              rd_en,
  input logic              wr_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic [CNT_W-1:0]  cnt,
  input logic              armed
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (!hrst_n)
    rd_data[DATA_W-1:CNT_W] == '0);

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!hrst_n)
    !rd_valid |-> rd_data == '0);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!hrst_n)
    (tx_start && !srst) |=> (cnt == '0 && armed));

  p_step_r3: assert property (@(posedge clk) disable iff (!hrst_n)
    (armed && carrier && tick && cnt != CMAX && !tx_start && !srst)
      |=> cnt == $past(cnt) + 1'b1);

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!hrst_n)
    (!tick && !tx_start && !srst) |=> $stable(cnt));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!hrst_n)
    (!armed && !tx_start && !srst) |=> ($stable(cnt) && !armed));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!hrst_n)
    (cnt == CMAX && !tx_start && !srst) |=> cnt == CMAX);

  p_soft_reset_r6: assert property (@(posedge clk) disable iff (!hrst_n)
    srst |=> (cnt == '0 && !armed && !rd_valid));

  p_read_r7: assert property (@(posedge clk) disable iff (!hrst_n)
    (rd_en && !wr_en && stop_mode && !srst)
      |=> (rd_valid && rd_data[CNT_W-1:0] == $past(cnt)));

  p_no_read_run_r8: assert property (@(posedge clk) disable iff (!hrst_n)
    !stop_mode |=> !rd_valid);

  p_write_blocks_r9: assert property (@(posedge clk) disable iff (!hrst_n)
    wr_en |=> !rd_valid);

endmodule

bind tdr_interval_counter tdr_interval_counter_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .hrst_n(hrst_n), .srst(srst), .tx_start(tx_start),
  .carrier(carrier), .tick(tick), .stop_mode(stop_mode), .rd_en(rd_en),
  .wr_en(wr_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .cnt(cnt), .armed(armed)
);

// File: tb/test_tdr_interval_counter.sv
`timescale 1ns/1ps
module test_tdr_interval_counter;

  logic clk = 0, hrst_n = 0, srst = 0, tx_start = 0, carrier = 0, tick = 0;
  logic stop_mode = 1, rd_en = 0, wr_en = 0;
  logic [15:0] rd_data;
  logic rd_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  integer m_cnt = 0, m_rd = 0;
  bit m_arm = 0, m_rv = 0;

  always #10 clk = ~clk;

  tdr_interval_counter i_tdr_interval_counter (
    .clk(clk), .hrst_n(hrst_n), .srst(srst), .tx_start(tx_start),
    .carrier(carrier), .tick(tick), .stop_mode(stop_mode), .rd_en(rd_en),
    .wr_en(wr_en), .rd_data(rd_data), .rd_valid(rd_valid));

  always @(posedge clk or negedge hrst_n) begin
    if (!hrst_n) begin
      m_cnt = 0; m_arm = 0; m_rv = 0; m_rd = 0;
    end else if (srst) begin
      m_cnt = 0; m_arm = 0; m_rv = 0; m_rd = 0;
    end else begin
      m_rv = rd_en && !wr_en && stop_mode;
      m_rd = m_rv ? m_cnt : 0;
      if (tx_start) begin m_cnt = 0; m_arm = 1; end
      else if (m_arm && !carrier) m_arm = 0;
      else if (m_arm && tick && m_cnt < 1023) m_cnt = m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (hrst_n && !done) begin
      checks++;
      if (rd_valid !== m_rv || rd_data !== m_rd[15:0]) begin
        fails++;
        $display("FAIL R7/R8 model: actual valid=%0b data=%0d expected valid=%0b data=%0d",
                 rd_valid, rd_data, m_rv, m_rd);
      end
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1;
      @(negedge clk) tick = 0;
      cyc(1);
    end
  endtask

  task automatic expect_read(input int exp, input string tag);
    @(negedge clk) rd_en = 1;
    @(negedge clk) rd_en = 0;
    checks++;
    if (rd_valid !== 1'b1 || rd_data !== exp[15:0]) begin
      fails++;
      $display("FAIL %s: actual valid=%0b data=%0d expected valid=1 data=%0d",
               tag, rd_valid, rd_data, exp);
    end
  endtask

  task automatic start_tx();
    @(negedge clk) tx_start = 1;
    @(negedge clk) tx_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    #3 hrst_n = 1;
    cyc(2);
    expect_read(0, "R6 reset value");

    carrier = 1;
    start_tx();
    ticks(5);
    expect_read(5, "R3 five ticks");
    @(negedge clk) carrier = 0;
    ticks(4);
    expect_read(5, "R4 frozen after carrier loss");

    @(negedge clk) wr_en = 1;
    cyc(3);
    @(negedge clk) wr_en = 0;
    expect_read(5, "R9 write ignored");

    @(negedge clk) begin rd_en = 1; wr_en = 1; end
    @(negedge clk) begin rd_en = 0; wr_en = 0; end
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 16'd0) begin
      fails++;
      $display("FAIL R9 read+write: actual valid=%0b data=%0d expected valid=0 data=0",
               rd_valid, rd_data);
    end

    carrier = 1;
    start_tx();
    expect_read(0, "R2 start clears");
    ticks(3);
    @(negedge clk) begin tick = 1; rd_en = 1; end
    @(negedge clk) begin tick = 0; rd_en = 0; end
    checks++;
    if (rd_valid !== 1'b1 || rd_data !== 16'd3) begin
      fails++;
      $display("FAIL R7 read on tick: actual valid=%0b data=%0d expected valid=1 data=3",
               rd_valid, rd_data);
    end
    expect_read(4, "R7 after tick");

    @(negedge clk) stop_mode = 0;
    @(negedge clk) rd_en = 1;
    @(negedge clk) rd_en = 0;
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== 16'd0) begin
      fails++;
      $display("FAIL R8 read outside stop: actual valid=%0b data=%0d expected valid=0 data=0",
               rd_valid, rd_data);
    end
    stop_mode = 1;

    @(negedge clk) begin tx_start = 1; tick = 1; end
    @(negedge clk) begin tx_start = 0; tick = 0; end
    expect_read(0, "R10 start beats tick");

    @(negedge clk) tick = 1;
    cyc(1100);
    @(negedge clk) tick = 0;
    expect_read(1023, "R5 saturation and R1 upper zero");

    @(negedge clk) begin srst = 1; tx_start = 1; end
    @(negedge clk) begin srst = 0; tx_start = 0; end
    ticks(3);
    expect_read(0, "R6 soft reset beats start");

    start_tx();
    ticks(7);
    @(negedge clk);
    #3 hrst_n = 0;
    cyc(2);
    #3 hrst_n = 1;
    ticks(2);
    expect_read(0, "R6 hard reset");

    start_tx();
    ticks(2);
    carrier = 0;
    cyc(2);
    expect_read(2, "R1 field bits 9..0");

    cyc(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule